// File: doc/BRIEF.md
# Triggered ROM Image Stream Source

This block holds a fixed program image of 32-bit words in an internal constant table. A one-cycle start pulse sends the whole image out once, in index order, on a valid/ready/last stream. The block shows whether a transfer is running and whether one has finished. A downstream sink may stall the stream at any time. The block is meant to seed a memory with a small boot program, for example through a width-converting bridge that packs the words into wider writes.

Next to the stream, the block writes a trace record for each step of the transfer: one when the transfer starts, one for each accepted word, and one when it completes. Every record carries a subsystem code, an event kind, four 64-bit arguments and a flags word that identifies the producer. A debug collector can rebuild the exact sequence of a run from these records.

Top module: `rom_burst_source`

## Requirements
- R1: The image is `IMG_WORDS` words long (default 96). Index 0 holds 0x401A7000, index 1 holds 0x275A0004, index 2 holds 0x03400008 and index 3 holds 0x42000010. From index 4 onward, even indices hold 0x03E00008 and odd indices hold 0x00000000. Words leave the block in ascending index order, starting at index 0.
- R2: A `start_i` pulse seen while idle is accepted. In the next cycle `busy_o` and `st_valid_o` are high and `st_data_o` presents word 0.
- R3: A word is transferred only on a cycle in which `st_valid_o` and `st_ready_i` are both high. While `st_valid_o` is high and `st_ready_i` is low, `st_data_o` and `st_last_o` hold their values into the next cycle. `st_ready_i` has no effect while the block is idle.
- R4: `st_last_o` is high only while word `IMG_WORDS-1` is being presented, and it is never high without `st_valid_o`.
- R5: In the cycle after the final word is accepted, `busy_o` and `st_valid_o` are low and `done_o` is high. `done_o` stays high until a start is accepted, and it is low from the cycle after that acceptance. `busy_o` and `done_o` are never high together.
- R6: `start_i` is ignored while `busy_o` is high and in the first cycle in which `done_o` is high. A start pulse in either window does not restart the stream or change the word index.
- R7: In the cycle after an accepted start, the trace port carries one record with `trc_valid_o`=1, `trc_unit_o`=0x03 (bus-interface subsystem), `trc_kind_o`=1 (start), `trc_arg0_o`=`IMG_WORDS`, `trc_arg1_o`, `trc_arg2_o` and `trc_arg3_o` all 0, and `trc_flags_o`={24'h0, `MASTER_ID`}. `MASTER_ID` is 8 bits wide and defaults to 6.
- R8: In the cycle after each accepted word, the trace port carries a record with unit 0x03, kind 2 (beat) and the same flags as in R7. `trc_arg0_o` is the word index, `trc_arg1_o` is the word zero-extended, `trc_arg2_o` is 1 for the final word and 0 otherwise, and `trc_arg3_o` is 0.
- R9: Two cycles after the final word is accepted, the trace port carries one record with unit 0x03, kind 3 (done), `trc_arg0_o`=`IMG_WORDS`, the other arguments 0 and the same flags as in R7.
- R10: In every other cycle `trc_valid_o` is low and all trace fields are zero. One run therefore yields exactly `IMG_WORDS`+2 records.
- R11: The reset `rst` is synchronous and active high. It clears the word index, `busy_o`, `done_o`, `st_valid_o` and `trc_valid_o`, so the next run starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start pulse |
| st_ready_i | input | 1 | Sink can accept a word |
| st_valid_o | output | 1 | A word is presented |
| st_data_o | output | 32 | Presented image word |
| st_last_o | output | 1 | Presented word is the final one |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer completed |
| trc_valid_o | output | 1 | Trace record present |
| trc_unit_o | output | 8 | Subsystem code |
| trc_kind_o | output | 4 | Event kind: 1 start, 2 beat, 3 done |
| trc_arg0_o | output | 64 | Argument 0 |
| trc_arg1_o | output | 64 | Argument 1 |
| trc_arg2_o | output | 64 | Argument 2 |
| trc_arg3_o | output | 64 | Argument 3 |
| trc_flags_o | output | 32 | Producer flags (master ID in the low byte) |

## Verification
A wrong word index shows up at once on `st_data_o` and `st_last_o` in the same cycle. It also shows up one cycle later in `trc_arg0_o` of the beat record, so a skipped or repeated word can be seen under every stall pattern. A wrong sequencer state shows up within a cycle as `busy_o` and `done_o` high together, as a start pulse that restarts a running stream, or as a completion record that is missing or arrives at the wrong time. The bench drives stall patterns of different density and, in some runs, holds the start input high throughout, so that each of these faults shows at the ports within one or two cycles.

// File: rtl/rom_burst_pkg.sv
package rom_burst_pkg;

    localparam int WORD_W = 32;
    localparam int ARG_W  = 64;
    localparam int FLAG_W = 32;
    localparam int UNIT_W = 8;

    localparam logic [UNIT_W-1:0] UNIT_BUSIF = 8'h03;

    typedef enum logic [3:0] {
        EVK_NONE  = 4'd0,
        EVK_START = 4'd1,
        EVK_BEAT  = 4'd2,
        EVK_DONE  = 4'd3
    } evk_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    // Step indications from the sequencer to the trace builder
    typedef struct packed {
        logic accept_go;
        logic beat;
        logic beat_last;
        logic fin;
    } seq_evt_t;

    typedef struct packed {
        logic              valid;
        logic [UNIT_W-1:0] unit;
        evk_e              kind;
        logic [ARG_W-1:0]  a0;
        logic [ARG_W-1:0]  a1;
        logic [ARG_W-1:0]  a2;
        logic [ARG_W-1:0]  a3;
        logic [FLAG_W-1:0] flags;
    } trace_rec_t;

    // Boot stub content: four head words, then a repeating return pair
    function automatic logic [WORD_W-1:0] image_word(input int unsigned idx);
        logic [WORD_W-1:0] w;
        case (idx)
            0:       w = 32'h401A7000;
            1:       w = 32'h275A0004;
            2:       w = 32'h03400008;
            3:       w = 32'h42000010;
            default: w = idx[0] ? 32'h00000000 : 32'h03E00008;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rom_burst_image.sv
module rom_burst_image
    import rom_burst_pkg::*;
#(
    parameter int IMG_WORDS = 96,
    parameter int IDX_W     = 7
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] rom [IMG_WORDS];

    for (genvar g = 0; g < IMG_WORDS; g++) begin : g_rom
        assign rom[g] = image_word(g);
    end

    always_comb begin
        word_o = '0;
        if (int'(idx_i) < IMG_WORDS) begin
            word_o = rom[idx_i];
        end
    end

endmodule

// File: rtl/rom_burst_seq.sv
module rom_burst_seq
    import rom_burst_pkg::*;
#(
    parameter int IMG_WORDS = 96,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o,
    output seq_evt_t         evt_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);

    seq_st_e          state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             at_last;

    assign at_last = (idx_q == LAST_IDX);

    always_comb begin
        evt_o.accept_go = (state_q == ST_IDLE) && start_i;
        evt_o.beat      = (state_q == ST_RUN) && ready_i;
        evt_o.beat_last = (state_q == ST_RUN) && ready_i && at_last;
        evt_o.fin       = (state_q == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (ready_i) begin
                        if (at_last) begin
                            state_q <= ST_FIN;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign valid_o = (state_q == ST_RUN);
    assign busy_o  = (state_q == ST_RUN);
    assign last_o  = (state_q == ST_RUN) && at_last;
    assign done_o  = done_q;
    assign idx_o   = idx_q;

    // R5
    busy_done_mutex_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R5
    last_accept_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.beat_last |=> (done_o && !busy_o));

    // R6
    go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !ready_i) |=> (busy_o && $stable(idx_o)));

    // R6
    go_at_fin_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.fin && start_i) |=> (!busy_o && done_o));

endmodule

// File: rtl/rom_burst_trace.sv
module rom_burst_trace
    import rom_burst_pkg::*;
#(
    parameter int          IMG_WORDS = 96,
    parameter int          IDX_W     = 7,
    parameter logic [7:0]  MASTER_ID = 8'd6
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] word_i,
    output trace_rec_t        rec_o
);

    localparam logic [FLAG_W-1:0] FLAGS  = FLAG_W'(MASTER_ID);
    localparam logic [ARG_W-1:0]  LENGTH = ARG_W'(IMG_WORDS);

    trace_rec_t rec_d;
    trace_rec_t rec_q;

    always_comb begin
        rec_d = '0;
        if (evt_i.accept_go) begin
            rec_d.valid = 1'b1;
            rec_d.kind  = EVK_START;
            rec_d.a0    = LENGTH;
        end else if (evt_i.beat) begin
            rec_d.valid = 1'b1;
            rec_d.kind  = EVK_BEAT;
            rec_d.a0    = ARG_W'(idx_i);
            rec_d.a1    = ARG_W'(word_i);
            rec_d.a2    = ARG_W'(evt_i.beat_last);
        end else if (evt_i.fin) begin
            rec_d.valid = 1'b1;
            rec_d.kind  = EVK_DONE;
            rec_d.a0    = LENGTH;
        end
        if (rec_d.valid) begin
            rec_d.unit  = UNIT_BUSIF;
            rec_d.flags = FLAGS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec_o = rec_q;

    // R7
    start_rec_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.accept_go |=> (rec_o.valid && rec_o.kind == EVK_START));

    // R9
    done_rec_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.fin |=> (rec_o.valid && rec_o.kind == EVK_DONE));

endmodule

// File: rtl/rom_burst_source.sv
module rom_burst_source
    import rom_burst_pkg::*;
#(
    parameter int         IMG_WORDS = 96,
    parameter logic [7:0] MASTER_ID = 8'd6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        st_ready_i,
    output logic        st_valid_o,
    output logic [31:0] st_data_o,
    output logic        st_last_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        trc_valid_o,
    output logic [7:0]  trc_unit_o,
    output logic [3:0]  trc_kind_o,
    output logic [63:0] trc_arg0_o,
    output logic [63:0] trc_arg1_o,
    output logic [63:0] trc_arg2_o,
    output logic [63:0] trc_arg3_o,
    output logic [31:0] trc_flags_o
);

    localparam int IDX_W = (IMG_WORDS > 1) ? $clog2(IMG_WORDS) : 1;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    seq_evt_t          evt;
    trace_rec_t        rec;

    rom_burst_seq #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ready_i (st_ready_i),
        .valid_o (st_valid_o),
        .last_o  (st_last_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .idx_o   (idx),
        .evt_o   (evt)
    );

    rom_burst_image #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W)) u_image (
        .idx_i  (idx),
        .word_o (word)
    );

    rom_burst_trace #(.IMG_WORDS(IMG_WORDS), .IDX_W(IDX_W), .MASTER_ID(MASTER_ID)) u_trace (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .idx_i  (idx),
        .word_i (word),
        .rec_o  (rec)
    );

    assign st_data_o   = word;
    assign trc_valid_o = rec.valid;
    assign trc_unit_o  = rec.unit;
    assign trc_kind_o  = rec.kind;
    assign trc_arg0_o  = rec.a0;
    assign trc_arg1_o  = rec.a1;
    assign trc_arg2_o  = rec.a2;
    assign trc_arg3_o  = rec.a3;
    assign trc_flags_o = rec.flags;

    // R3
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_data_o) && $stable(st_last_o)));

    // R4
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        st_last_o |-> st_valid_o);

    // R8
    beat_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid_o && st_ready_i) |=> (trc_valid_o && trc_kind_o == 4'd2));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/rom_burst_source_tb.sv
`timescale 1ns/1ps
module rom_burst_source_tb;

    localparam int  LEN    = 96;
    localparam int  MID    = 6;
    localparam time CLK_HP = 4ns;

    // Table: bit 16 = hold start high during the run, bits 15:0 = ready pattern
    localparam int NVEC = 5;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'hFFFF},
        {1'b0, 16'hAAAA},
        {1'b1, 16'h8421},
        {1'b1, 16'hF0F0},
        {1'b0, 16'h7FFE}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        st_ready_i;
    logic        st_valid_o;
    logic [31:0] st_data_o;
    logic        st_last_o;
    logic        busy_o;
    logic        done_o;
    logic        trc_valid_o;
    logic [7:0]  trc_unit_o;
    logic [3:0]  trc_kind_o;
    logic [63:0] trc_arg0_o, trc_arg1_o, trc_arg2_o, trc_arg3_o;
    logic [31:0] trc_flags_o;

    int n_chk = 0;
    int n_err = 0;
    int ev_cnt = 0;
    bit hung = 1'b0;

    always #CLK_HP clk = ~clk;

    rom_burst_source u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .st_ready_i(st_ready_i),
        .st_valid_o(st_valid_o), .st_data_o(st_data_o), .st_last_o(st_last_o),
        .busy_o(busy_o), .done_o(done_o), .trc_valid_o(trc_valid_o),
        .trc_unit_o(trc_unit_o), .trc_kind_o(trc_kind_o),
        .trc_arg0_o(trc_arg0_o), .trc_arg1_o(trc_arg1_o),
        .trc_arg2_o(trc_arg2_o), .trc_arg3_o(trc_arg3_o),
        .trc_flags_o(trc_flags_o)
    );

    always @(negedge clk) if (trc_valid_o === 1'b1) ev_cnt++;

    function automatic logic [31:0] exp_word(input int i);
        if (i == 0) return 32'h401A7000;
        if (i == 1) return 32'h275A0004;
        if (i == 2) return 32'h03400008;
        if (i == 3) return 32'h42000010;
        return (i % 2 == 0) ? 32'h03E00008 : 32'h00000000;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rec(input string req, input int kind, input logic [63:0] a0,
                           input logic [63:0] a1, input logic [63:0] a2);
        chk({req, " valid"}, 64'(trc_valid_o), 64'd1);
        chk({req, " unit"},  64'(trc_unit_o),  64'h03);
        chk({req, " kind"},  64'(trc_kind_o),  64'(kind));
        chk({req, " arg0"},  trc_arg0_o, a0);
        chk({req, " arg1"},  trc_arg1_o, a1);
        chk({req, " arg2"},  trc_arg2_o, a2);
        chk({req, " arg3"},  trc_arg3_o, 64'd0);
        chk({req, " flags"}, 64'(trc_flags_o), 64'(MID));
    endtask

    task automatic chk_quiet(input string req);
        chk({req, " trc_valid"}, 64'(trc_valid_o), 64'd0);
        chk({req, " trc_fields"},
            64'(trc_unit_o) | 64'(trc_kind_o) | trc_arg0_o | trc_arg1_o | trc_arg2_o
            | trc_arg3_o | 64'(trc_flags_o), 64'd0);
    endtask

    task automatic run_case(input logic [15:0] pat, input bit spam);
        int idx = 0;
        int prev_idx = 0;
        bit prev_hs = 1'b0;
        bit first = 1'b1;
        bit fin = 1'b0;
        int k = 0;
        @(negedge clk);
        ev_cnt = 0;
        start_i = 1'b1;
        st_ready_i = 1'b0;
        @(negedge clk);
        start_i = spam;
        while (!fin && !hung && k < 4000) begin
            st_ready_i = pat[k % 16];
            #1;
            chk("R2 busy",  64'(busy_o),     64'd1);
            chk("R2 valid", 64'(st_valid_o), 64'd1);
            chk("R5 done low while running", 64'(done_o), 64'd0);
            chk("R1 data",  64'(st_data_o),  64'(exp_word(idx)));
            chk("R4 last",  64'(st_last_o),  64'(idx == LEN - 1));
            if (first) chk_rec("R7 start record", 1, 64'(LEN), 64'd0, 64'd0);
            else if (prev_hs) chk_rec("R8 beat record", 2, 64'(prev_idx),
                                      64'(exp_word(prev_idx)), 64'(prev_idx == LEN - 1));
            else chk_quiet("R10 stall cycle");
            prev_hs = st_ready_i;
            prev_idx = idx;
            if (st_ready_i) begin
                if (idx == LEN - 1) fin = 1'b1;
                else idx++;
            end
            first = 1'b0;
            k++;
            @(negedge clk);
        end
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL R5: stream never finished, actual index %0d expected %0d", idx, LEN - 1);
        end
        // first done cycle, start held high when spam is set (R6)
        start_i = spam;
        st_ready_i = 1'b0;
        #1;
        chk("R5 done rises", 64'(done_o), 64'd1);
        chk("R5 busy falls", 64'(busy_o), 64'd0);
        chk("R5 valid falls", 64'(st_valid_o), 64'd0);
        chk_rec("R8 final beat record", 2, 64'(LEN - 1), 64'(exp_word(LEN - 1)), 64'd1);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk_rec("R9 done record", 3, 64'(LEN), 64'd0, 64'd0);
        chk("R6 start ignored in first done cycle", 64'(busy_o), 64'd0);
        chk("R5 done holds", 64'(done_o), 64'd1);
        @(negedge clk);
        #1;
        chk_quiet("R10 after run");
        chk("R5 done still held", 64'(done_o), 64'd1);
        chk("R10 record count", 64'(ev_cnt), 64'(LEN + 2));
    endtask

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        st_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset busy",  64'(busy_o),     64'd0);
        chk("R11 reset done",  64'(done_o),     64'd0);
        chk("R11 reset valid", 64'(st_valid_o), 64'd0);
        chk("R4 reset last",   64'(st_last_o),  64'd0);
        chk_quiet("R11 reset trace");
        @(negedge clk);
        rst = 1'b0;

        // ready while idle has no effect (R3)
        st_ready_i = 1'b1;
        repeat (4) begin
            @(negedge clk);
            #1;
            chk("R3 idle valid", 64'(st_valid_o), 64'd0);
            chk("R3 idle busy",  64'(busy_o),     64'd0);
            chk_quiet("R10 idle");
        end

        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][15:0], VEC[v][16]);
        end

        // reset in the middle of a run (R11), then a full run from index 0
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        st_ready_i = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R11 mid reset busy",  64'(busy_o),     64'd0);
        chk("R11 mid reset valid", 64'(st_valid_o), 64'd0);
        chk("R11 mid reset done",  64'(done_o),     64'd0);
        chk("R11 mid reset trace", 64'(trc_valid_o), 64'd0);
        rst = 1'b0;
        run_case(16'hFFFF, 1'b0);

        // done clears in the cycle after the next accepted start (R5)
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        st_ready_i = 1'b0;
        #1;
        chk("R5 done clears on restart", 64'(done_o), 64'd0);
        chk("R2 restart data word 0", 64'(st_data_o), 64'(exp_word(0)));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(2 * CLK_HP * 150000);
        hung = 1'b1;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule